// File: doc/BRIEF.md
# Free-Running Clock Cycle Counter

This block counts edges of one chosen source clock in a wide counter that never stops on its own. Software sets up the counter through a configuration word on a bus-clock register port. It then reads the count as two words at two points in time and divides the difference by the time between the reads to get the frequency of the source. The counter lives in the counted clock's domain. Control bits cross into that domain through two-flop synchronisers. The count comes back to the bus domain as a snapshot carried by a toggle handshake.

The register map has three words. Address 0 is the configuration word. Address 1 holds the low part of the snapshot and address 2 the high part. The configuration word has these fields: bit 0 is hold (counter reset, 1 after bus reset), bit 1 is run (count enable), bit 2 is follow (keep refreshing the snapshot), bit 3 is grab (a write of 1 takes one snapshot and the bit always reads 0), and bits 5:4 are sel (source index). Every other bit reads 0. Writes take effect at the bus clock edge that samples `wr_en`. Read data is registered and appears one bus cycle after `rd_en`.

Top module: `ccnt_top`

## Requirements
- R1: After bus reset the configuration word reads 0x01 (hold set, all else clear), and both count words read 0.
- R2: While hold is released and run is set, the count rises by exactly one per cycle of the selected source. Two reads separated by a known interval therefore differ by the interval divided by the source period.
- R3: The count is CNT_W = 36 bits wide. Address 1 returns bits LO_W-1:0 (LO_W = 32). Address 2 returns the remaining CNT_W-LO_W bits in its lowest bits, and all its higher bits read 0.
- R4: A read of address 1 latches the high part of the same snapshot. Later reads of address 2 return that latched value until the next read of address 1, even if newer snapshots arrive.
- R5: The count is cleared only after hold has been seen for RST_CYCLES = 16 consecutive cycles of the counted clock. A shorter hold pulse leaves the count value intact.
- R6: A write sets run only if hold was 0 before the write and the write also sets hold to 0. Otherwise run is stored as 0. Releasing hold and enabling counting therefore take two separate writes.
- R7: The sel field takes a new value only from a write made while the stored hold bit is 1. Otherwise sel keeps its value.
- R8: With follow set, the snapshot keeps refreshing from the live count. With follow clear, the snapshot stays fixed while the counter keeps running.
- R9: Writing 1 to the grab bit takes exactly one fresh snapshot, whatever the state of follow. The grab bit reads back as 0.
- R10: The count wraps modulo 2^CNT_W. The difference between two readings, taken modulo 2^CNT_W, still gives the number of elapsed cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset; also resets the counted-clock domain through a synchroniser |
| src_clk | input | N_SRC | Candidate source clocks; the one chosen by sel is counted |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 32 | Registered read data, valid one bus cycle after rd_en |

## Verification
Some faults appear within a few counted cycles as a count that is wrong in level rather than in rate:
- A settle counter with the wrong threshold either clears the count after a short hold pulse or fails to clear it after a long one.
- A gating fault in the run qualifier lets the count start in the same write that releases hold.

Some faults show at the ports only after the snapshot loop has been exercised long enough:
- A torn or stale snapshot path shows up as two readings whose difference is far from the expected interval divided by the period.
- A broken high-word latch shows up only when the high part changes between two reads of address 2, which takes hundreds of counted cycles. The bench therefore uses a narrow instance for this case and for the wrap case.

// File: rtl/ccnt_pkg.sv
`timescale 1ns/1ps
package ccnt_pkg;

  localparam int BUS_W = 32;
  localparam int SEL_W = 2;

  // configuration word bit positions
  localparam int B_HOLD   = 0;
  localparam int B_RUN    = 1;
  localparam int B_FOLLOW = 2;
  localparam int B_GRAB   = 3;
  localparam int B_SEL    = 4;

  // word addresses
  localparam logic [1:0] A_CFG = 2'd0;
  localparam logic [1:0] A_LO  = 2'd1;
  localparam logic [1:0] A_HI  = 2'd2;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             follow;
    logic             run;
    logic             hold;
  } ccnt_cfg_t;

  localparam ccnt_cfg_t CFG_RST = '{sel: '0, follow: 1'b0, run: 1'b0, hold: 1'b1};

  // Next configuration after a write: run needs hold released both before
  // and by the write; sel moves only while hold is already stored.
  function automatic ccnt_cfg_t cfg_next(input ccnt_cfg_t old, input logic [BUS_W-1:0] w);
    ccnt_cfg_t n;
    n.hold   = w[B_HOLD];
    n.follow = w[B_FOLLOW];
    n.run    = w[B_RUN] & ~old.hold & ~w[B_HOLD];
    n.sel    = old.hold ? w[B_SEL +: SEL_W] : old.sel;
    return n;
  endfunction

  function automatic logic [BUS_W-1:0] cfg_word(input ccnt_cfg_t c);
    logic [BUS_W-1:0] r;
    r = '0;
    r[B_HOLD]           = c.hold;
    r[B_RUN]            = c.run;
    r[B_FOLLOW]         = c.follow;
    r[B_SEL +: SEL_W]   = c.sel;
    return r;
  endfunction

endpackage

// File: rtl/ccnt_sync.sv
`timescale 1ns/1ps
module ccnt_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/ccnt_core.sv
`timescale 1ns/1ps
module ccnt_core #(
  parameter int CNT_W      = 36,
  parameter int RST_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             run_i,
  input  logic             follow_i,
  input  logic             grab_tgl_i,
  input  logic             ack_tgl_i,
  output logic             req_tgl_o,
  output logic [CNT_W-1:0] snap_o
);

  localparam int SET_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(RST_CYCLES - 1);

  logic rst_s, run_s, follow_s, grab_s, ack_s;

  ccnt_sync #(.W(5)) u_ctl_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({hold_i, run_i, follow_i, grab_tgl_i, ack_tgl_i}),
    .q     ({rst_s, run_s, follow_s, grab_s, ack_s})
  );

  // named internal events
  logic [SET_W-1:0] settle;
  logic             clear_now;
  logic             inc_en;
  logic             busy;
  logic             capture;
  logic             grab_q;
  logic             grab_edge;
  logic             pend;
  logic [CNT_W-1:0] count;

  assign clear_now = rst_s && (settle == SET_LAST);
  assign inc_en    = !rst_s && run_s;
  assign busy      = req_tgl_o != ack_s;
  assign grab_edge = grab_s ^ grab_q;
  assign capture   = !busy && (follow_s || pend || grab_edge);

  // reset settle: counts consecutive cycles with hold seen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle <= '0;
    end else if (!rst_s) begin
      settle <= '0;
    end else if (settle != SET_LAST) begin
      settle <= settle + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear_now) begin
      count <= '0;
    end else if (inc_en) begin
      count <= count + 1'b1;
    end
  end

  // snapshot launch side of the toggle handshake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grab_q    <= 1'b0;
      pend      <= 1'b0;
      req_tgl_o <= 1'b0;
      snap_o    <= '0;
    end else begin
      grab_q <= grab_s;
      pend   <= (pend | grab_edge) & ~capture;
      if (capture) begin
        snap_o    <= count;
        req_tgl_o <= ~req_tgl_o;
      end
    end
  end

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_now |=> (count == $past(count)) || (count == CNT_W'($past(count) + CNT_W'(1))));

  // R5
  short_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_s && settle != SET_LAST) |=> $stable(count));

  // R8
  snap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(snap_o));

endmodule

// File: rtl/ccnt_regs.sv
`timescale 1ns/1ps
module ccnt_regs
  import ccnt_pkg::*;
#(
  parameter int CNT_W = 36,
  parameter int LO_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [1:0]       rd_addr,
  output logic [BUS_W-1:0] rd_data,
  output ccnt_cfg_t        cfg_o,
  output logic             grab_tgl_o,
  input  logic             req_tgl_i,
  input  logic [CNT_W-1:0] snap_i,
  output logic             ack_tgl_o
);

  localparam int HI_W = CNT_W - LO_W;

  logic             wr_cfg;
  logic             lo_rd;
  logic             req_s;
  logic             snap_load;
  logic [CNT_W-1:0] bus_snap;
  logic [HI_W-1:0]  hi_hold;

  assign wr_cfg    = wr_en && (wr_addr == A_CFG);
  assign lo_rd     = rd_en && (rd_addr == A_LO);
  assign snap_load = req_s != ack_tgl_o;

  ccnt_sync #(.W(1)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (req_tgl_i),
    .q     (req_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o      <= CFG_RST;
      grab_tgl_o <= 1'b0;
    end else if (wr_cfg) begin
      cfg_o <= cfg_next(cfg_o, wr_data);
      if (wr_data[B_GRAB]) grab_tgl_o <= ~grab_tgl_o;
    end
  end

  // snapshot receive side; the launch side holds snap_i until acknowledged
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_snap  <= '0;
      ack_tgl_o <= 1'b0;
    end else begin
      ack_tgl_o <= req_s;
      if (snap_load) bus_snap <= snap_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_hold <= '0;
    end else if (lo_rd) begin
      hi_hold <= bus_snap[CNT_W-1:LO_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        A_CFG:   rd_data <= cfg_word(cfg_o);
        A_LO:    rd_data <= BUS_W'(bus_snap[LO_W-1:0]);
        A_HI:    rd_data <= BUS_W'(hi_hold);
        default: rd_data <= '0;
      endcase
    end
  end

  // R6
  run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && cfg_o.hold) |=> !cfg_o.run);

  // R7
  sel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_o.hold |=> $stable(cfg_o.sel));

  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_load |=> $stable(bus_snap));

  // R4
  hi_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_rd |=> $stable(hi_hold));

endmodule

// File: rtl/ccnt_top.sv
`timescale 1ns/1ps
module ccnt_top
  import ccnt_pkg::*;
#(
  parameter int CNT_W      = 36,
  parameter int LO_W       = 32,
  parameter int N_SRC      = 3,
  parameter int RST_CYCLES = 16
) (
  input  logic             bus_clk,
  input  logic             bus_rst_n,
  input  logic [N_SRC-1:0] src_clk,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             rd_en,
  input  logic [1:0]       rd_addr,
  output logic [31:0]      rd_data
);

  localparam int NPAD = 1 << SEL_W;

  ccnt_cfg_t        cfg;
  logic             grab_tgl;
  logic             req_tgl;
  logic             ack_tgl;
  logic [CNT_W-1:0] snap;
  logic [NPAD-1:0]  src_pad;
  logic             cnt_clk;
  logic             cnt_rst_n;

  // source choice; sel only moves while the counter is held
  always_comb begin
    src_pad = '0;
    src_pad[N_SRC-1:0] = src_clk;
  end
  assign cnt_clk = src_pad[cfg.sel];

  ccnt_sync #(.W(1)) u_cnt_rst (
    .clk   (cnt_clk),
    .rst_n (bus_rst_n),
    .d     (1'b1),
    .q     (cnt_rst_n)
  );

  ccnt_regs #(.CNT_W(CNT_W), .LO_W(LO_W)) u_regs (
    .clk        (bus_clk),
    .rst_n      (bus_rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .cfg_o      (cfg),
    .grab_tgl_o (grab_tgl),
    .req_tgl_i  (req_tgl),
    .snap_i     (snap),
    .ack_tgl_o  (ack_tgl)
  );

  ccnt_core #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_core (
    .clk        (cnt_clk),
    .rst_n      (cnt_rst_n),
    .hold_i     (cfg.hold),
    .run_i      (cfg.run),
    .follow_i   (cfg.follow),
    .grab_tgl_i (grab_tgl),
    .ack_tgl_i  (ack_tgl),
    .req_tgl_o  (req_tgl),
    .snap_o     (snap)
  );

endmodule

// File: tb/test_ccnt_top.sv
`timescale 1ns/1ps
module test_ccnt_top;

  logic bus_clk = 1'b0;
  logic bus_rst_n = 1'b0;
  logic [2:0] src_clk = 3'b000;

  logic        wr_en0 = 0, wr_en1 = 0, rd_en0 = 0, rd_en1 = 0;
  logic [1:0]  wr_addr0 = 0, wr_addr1 = 0, rd_addr0 = 0, rd_addr1 = 0;
  logic [31:0] wr_data0 = 0, wr_data1 = 0;
  logic [31:0] rd_data0, rd_data1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4  bus_clk = ~bus_clk;     // 125 MHz
  always #10 src_clk[0] = ~src_clk[0]; // 20 ns
  always #15 src_clk[1] = ~src_clk[1]; // 30 ns
  always #7  src_clk[2] = ~src_clk[2]; // 14 ns

  ccnt_top i_ccnt_top (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .src_clk(src_clk),
    .wr_en(wr_en0), .wr_addr(wr_addr0), .wr_data(wr_data0),
    .rd_en(rd_en0), .rd_addr(rd_addr0), .rd_data(rd_data0)
  );

  ccnt_top #(.CNT_W(12), .LO_W(8)) i_ccnt_top_nar (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .src_clk(src_clk),
    .wr_en(wr_en1), .wr_addr(wr_addr1), .wr_data(wr_data1),
    .rd_en(rd_en1), .rd_addr(rd_addr1), .rd_data(rd_data1)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_bus(input int n);
    repeat (n) @(negedge bus_clk);
  endtask

  task automatic wr(input int k, input logic [1:0] a, input logic [31:0] d);
    if (k == 0) begin wr_en0 = 1; wr_addr0 = a; wr_data0 = d; end
    else        begin wr_en1 = 1; wr_addr1 = a; wr_data1 = d; end
    @(negedge bus_clk);
    wr_en0 = 0; wr_en1 = 0;
  endtask

  task automatic rd(input int k, input logic [1:0] a, output logic [31:0] d);
    if (k == 0) begin rd_en0 = 1; rd_addr0 = a; end
    else        begin rd_en1 = 1; rd_addr1 = a; end
    @(negedge bus_clk);
    rd_en0 = 0; rd_en1 = 0;
    d = (k == 0) ? rd_data0 : rd_data1;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    rd(0, 2'd0, v); chk(v == 32'h01, "R1", "cfg after reset", v, 32'h01);
    rd(0, 2'd1, v); chk(v == 0, "R1", "low word after reset", v, 0);
    rd(0, 2'd2, v); chk(v == 0, "R1", "high word after reset", v, 0);
  endtask

  task automatic t_enable_order();
    logic [31:0] v;
    wr(0, 2'd0, 32'h06);  // release hold and ask for run together
    rd(0, 2'd0, v); chk(v == 32'h04, "R6", "run dropped in releasing write", v, 32'h04);
    wait_bus(200);
    rd(0, 2'd1, v); chk(v == 0, "R6", "count idle without run", v, 0);
    wr(0, 2'd0, 32'h06);
    rd(0, 2'd0, v); chk(v == 32'h06, "R6", "run taken in later write", v, 32'h06);
  endtask

  task automatic t_rate_sel_lock();
    logic [31:0] a, b, h;
    wait_bus(50);
    rd(0, 2'd1, a);
    wait_bus(1500);
    rd(0, 2'd1, b);
    // 1501 bus cycles * 8 ns / 20 ns = 600
    chk((b - a) >= 590 && (b - a) <= 611, "R2", "delta on source 0", b - a, 600);
    rd(0, 2'd2, h); chk(h == 0, "R3", "high word zero for small count", h, 0);
    wr(0, 2'd0, 32'h16);
    rd(0, 2'd0, a); chk(a == 32'h06, "R7", "sel ignored while running", a, 32'h06);
  endtask

  task automatic t_follow_grab();
    logic [31:0] x, y, z, c;
    wr(0, 2'd0, 32'h02);
    wait_bus(50);
    rd(0, 2'd1, x);
    wait_bus(500);
    rd(0, 2'd1, y); chk(y == x, "R8", "snapshot fixed with follow clear", y, x);
    wr(0, 2'd0, 32'h0A);
    rd(0, 2'd0, c); chk(c == 32'h02, "R9", "grab reads back zero", c, 32'h02);
    wait_bus(100);
    rd(0, 2'd1, z);
    chk((z - x) > 200 && (z - x) < 300, "R9", "grab refreshes snapshot", z - x, 245);
    wait_bus(300);
    rd(0, 2'd1, y); chk(y == z, "R9", "single snapshot per grab", y, z);
  endtask

  task automatic t_reset_len();
    logic [31:0] v, w;
    wr(0, 2'd0, 32'h06);
    wait_bus(100);
    rd(0, 2'd1, v);
    wr(0, 2'd0, 32'h05);  // short hold pulse
    wait_bus(8);
    wr(0, 2'd0, 32'h04);
    wr(0, 2'd0, 32'h06);
    wait_bus(200);
    rd(0, 2'd1, w); chk(w > v, "R5", "short hold keeps count", w, v);
    wr(0, 2'd0, 32'h05);
    wait_bus(100);
    rd(0, 2'd1, w); chk(w == 0, "R5", "long hold clears count", w, 0);
  endtask

  task automatic t_source_switch();
    logic [31:0] a, b;
    wr(0, 2'd0, 32'h15);
    rd(0, 2'd0, a); chk(a == 32'h15, "R7", "sel taken while held", a, 32'h15);
    wait_bus(20);
    wr(0, 2'd0, 32'h14);
    wr(0, 2'd0, 32'h16);
    wait_bus(50);
    rd(0, 2'd1, a);
    wait_bus(1500);
    rd(0, 2'd1, b);
    // 1501 * 8 / 30 = 400
    chk((b - a) >= 390 && (b - a) <= 411, "R2", "delta on source 1", b - a, 400);
  endtask

  task automatic t_small_freeze();
    logic [31:0] l, h1, h2, h3;
    wr(1, 2'd0, 32'h04);
    wr(1, 2'd0, 32'h06);
    wait_bus(700);
    rd(1, 2'd1, l);
    rd(1, 2'd2, h1);
    chk(h1[31:4] == 0, "R3", "high word upper bits zero", h1[31:4], 0);
    wait_bus(1000);
    rd(1, 2'd2, h2); chk(h2 == h1, "R4", "high word frozen until low read", h2, h1);
    rd(1, 2'd1, l);
    rd(1, 2'd2, h3); chk(h3 != h1, "R4", "high word follows next low read", h3, h1 + 1);
  endtask

  task automatic t_small_wrap();
    logic [31:0] l, h;
    logic [11:0] prev, cur, d;
    int wraps = 0;
    rd(1, 2'd1, l); rd(1, 2'd2, h);
    prev = {h[3:0], l[7:0]};
    for (int i = 0; i < 24; i++) begin
      wait_bus(500);
      rd(1, 2'd1, l); rd(1, 2'd2, h);
      cur = {h[3:0], l[7:0]};
      d = cur - prev;
      // 502 bus cycles * 8 / 20 = 200.8 counts, taken modulo 4096
      chk(d >= 190 && d <= 212, "R10", "modular delta", d, 201);
      if (cur < prev) wraps++;
      prev = cur;
    end
    chk(wraps >= 1, "R10", "wrap seen", wraps, 1);
  endtask

  initial begin
    wait_bus(10);
    bus_rst_n = 1'b1;
    wait_bus(2);
    t_reset_state();
    t_enable_order();
    t_rate_sel_lock();
    t_follow_grab();
    t_reset_len();
    t_source_switch();
    t_small_freeze();
    t_small_wrap();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge bus_clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule